// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block connects a single-word request port to an asynchronous DRAM with a multiplexed address bus. The DRAM takes each word address in two halves on the same pins: the row half is captured when the row strobe falls and the column half when the column strobe falls. Both strobes are active low. After a row has been opened, the controller keeps the row strobe low. Later requests to the same row then cost only a column cycle. A request to a different row first closes the open row, waits out the precharge time, and then opens the new row.

All DRAM timing is given as nanosecond parameters. The block converts each one to clock cycles by rounding up. It enforces the row cycle time between row openings, the minimum row strobe low time, the precharge time, the row-to-column delay, the column access time and the minimum spacing of column cycles. A refresh timer spreads the refresh window evenly over the rows. When a refresh falls due, the controller stops taking requests, closes any open row and runs a row-only cycle at the next refresh row. Read data is captured a fixed number of cycles after the column strobe falls and is returned with a one-cycle valid pulse.

The request port uses valid/ready. A requester raises `req_valid` and holds `req_we`, `req_addr` and `req_wdata` stable until it samples `req_ready` high at a clock edge. The controller may hold `req_ready` low for any number of cycles. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and the consumer must take `rsp_rdata` in that cycle. Responses return in request order, and only reads produce one.

Top module: `pgdram_ctrl`

## Requirements
- R1: The upper ROW_W bits of `req_addr` are driven on `dram_addr` when `dram_ras_n` falls. The lower COL_W bits are driven on `dram_addr` when `dram_cas_n` falls.
- R2: A request accepted while a row is open and whose row half matches that row is served with a column cycle only, with no new falling edge of `dram_ras_n`.
- R3: A request to a row that is not open causes exactly one new falling edge of `dram_ras_n`. Before that edge, `dram_ras_n` has been high for at least T_RP cycles (ceil(50 ns / clock)).
- R4: Successive falling edges of `dram_ras_n` are at least T_RC cycles apart (ceil(110 ns / clock)). Each low period of `dram_ras_n` lasts at least T_RAS cycles (ceil(60 ns / clock)).
- R5: `dram_cas_n` falls only while `dram_ras_n` is low and at least T_RCD cycles after the row strobe fell (ceil(45 ns / clock)). Successive column strobe falls are at least T_PC cycles apart (ceil(35 ns / clock)). Each column strobe low period lasts at least T_CAC cycles (ceil(15 ns / clock)).
- R6: During a write column cycle, `dram_we_n` is 0 and `dram_wdata` carries the request data when `dram_cas_n` falls. During a read column cycle, `dram_we_n` is 1. Exactly T_CAC cycles after that fall, `rsp_valid` pulses for one cycle, with `rsp_rdata` holding the DRAM data.
- R7: A row-only cycle (a row strobe low period with no column strobe) refreshes the next row. The row address starts at 0 after reset and increments by one each time, wrapping. Consecutive refresh cycles are at most REF_CYC plus a small service latency apart, where REF_CYC = ceil(8 ms / (clock x 2^ROW_W)).
- R8: When a refresh is due, `req_ready` is low. An open row is closed, the refresh runs, and the row strobe is then left high.
- R9: Each accepted request produces exactly one column cycle. `req_ready` stays low from the acceptance of a request until its column cycle has started.
- R10: During reset and on release of reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1 and `rsp_valid` is 0. `req_ready` is 1 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row half in the upper bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_wdata | output | DATA_W | Data to the DRAM |
| dram_rdata | input | DATA_W | Data from the DRAM |

## Verification
A wrong open-row record shows up at the ports in one of two ways, both at the very next column strobe of the affected request. Either a hit pays an unneeded row opening, or a different row is read through the wrong page and returns stale data. A timing counter that saturates or restarts on the wrong event shows up as strobe edges that come earlier than the nanosecond minimum. A bench that timestamps every edge of the row and column strobes measures these spacings directly. A slipped refresh pointer or timer shows up as a row-only cycle with an out-of-sequence address, or as a refresh gap longer than the interval. Both are visible within one refresh period.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

  typedef enum logic [1:0] {ASEL_ROW, ASEL_COL, ASEL_REF} asel_e;

  typedef enum logic [2:0] {ST_IDLE, ST_OPEN, ST_ISSUE, ST_CAS, ST_REF} st_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction

endpackage

// File: rtl/pgdram_age.sv
// Saturating age counter: cycles since the last restart event.
module pgdram_age #(
  parameter int unsigned MAX = 14,
  parameter int unsigned W   = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] age
);
  localparam logic [W-1:0] MAX_C = W'(MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)              age <= MAX_C;
    else if (restart)        age <= W'(1);
    else if (age < MAX_C)    age <= age + 1'b1;
  end

  assert_age_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    age <= MAX_C);
  assert_age_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> age == W'(1));
endmodule

// File: rtl/pgdram_refresh.sv
// Refresh scheduler: raises a request every INTERVAL cycles, walks rows.
module pgdram_refresh #(
  parameter int unsigned ROW_W    = 8,
  parameter int unsigned INTERVAL = 3907
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  output logic             pend,
  output logic [ROW_W-1:0] row
);
  localparam int unsigned CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] LAST_C = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == LAST_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
      row  <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
      if (ack)      row  <= row + 1'b1;
    end
  end

  assert_ack_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend);
  assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> row == $past(row) + 1'b1);
endmodule

// File: rtl/pgdram_addr_mux.sv
// Chooses what goes onto the shared DRAM address pins.
module pgdram_addr_mux
  import pgdram_pkg::*;
#(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned COL_W = 8,
  parameter int unsigned A_W   = 8
) (
  input  asel_e            sel,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] ref_row,
  output logic [A_W-1:0]   addr
);
  always_comb begin
    unique case (sel)
      ASEL_COL: addr = A_W'(col);
      ASEL_REF: addr = A_W'(ref_row);
      default:  addr = A_W'(row);
    endcase
  end
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
  import pgdram_pkg::*;
#(
  parameter int unsigned ROW_W      = 8,
  parameter int unsigned COL_W      = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CLK_NS     = 8,
  parameter int unsigned RAC_NS     = 60,
  parameter int unsigned RC_NS      = 110,
  parameter int unsigned CAC_NS     = 15,
  parameter int unsigned PC_NS      = 35,
  parameter int unsigned RP_NS      = 50,
  parameter int unsigned REFWIN_NS  = 8000000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_we,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     dram_ras_n,
  output logic                     dram_cas_n,
  output logic                     dram_we_n,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]        dram_wdata,
  input  logic [DATA_W-1:0]        dram_rdata
);
  localparam int unsigned A_W     = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int unsigned T_RAS   = cyc_of(RAC_NS, CLK_NS);
  localparam int unsigned T_RC    = cyc_of(RC_NS, CLK_NS);
  localparam int unsigned T_CAC   = cyc_of(CAC_NS, CLK_NS);
  localparam int unsigned T_PC    = cyc_of(PC_NS, CLK_NS);
  localparam int unsigned T_RP    = cyc_of(RP_NS, CLK_NS);
  localparam int unsigned T_RCD   = cyc_of(RAC_NS - CAC_NS, CLK_NS);
  localparam int unsigned ROWS    = 1 << ROW_W;
  localparam int unsigned REF_CYC = cyc_of(REFWIN_NS, CLK_NS * ROWS);
  localparam int unsigned AGE_MAX = T_RC + T_RP + T_PC + T_RAS;
  localparam int unsigned AGE_W   = $clog2(AGE_MAX + 1) + 1;

  localparam logic [AGE_W-1:0] RAS_C = AGE_W'(T_RAS);
  localparam logic [AGE_W-1:0] RC_C  = AGE_W'(T_RC);
  localparam logic [AGE_W-1:0] CAC_C = AGE_W'(T_CAC);
  localparam logic [AGE_W-1:0] PC_C  = AGE_W'(T_PC);
  localparam logic [AGE_W-1:0] RP_C  = AGE_W'(T_RP);
  localparam logic [AGE_W-1:0] RCD_C = AGE_W'(T_RCD);

  // ---------------- state ----------------
  st_e               st, st_nx;
  logic              row_open;
  logic [ROW_W-1:0]  open_row;
  logic              cur_we;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic [DATA_W-1:0] cur_wdata;

  logic ras_fall_go, ras_rise_go, cas_fall_go, cas_rise_go, ref_ack;
  logic accept, hit, can_open, can_close, can_cas;
  asel_e sel_nx;
  logic [A_W-1:0] addr_nx;

  logic [AGE_W-1:0] ras_age, rp_age, cas_age;
  logic             ref_pend;
  logic [ROW_W-1:0] ref_row;

  // ---------------- timing ages ----------------
  logic [2:0]             age_restart;
  logic [2:0][AGE_W-1:0]  age_val;
  assign age_restart = {cas_fall_go, ras_rise_go, ras_fall_go};

  generate
    for (genvar g = 0; g < 3; g++) begin : g_age
      pgdram_age #(.MAX(AGE_MAX), .W(AGE_W)) u_age (
        .clk(clk), .rst_n(rst_n), .restart(age_restart[g]), .age(age_val[g]));
    end
  endgenerate

  assign ras_age = age_val[0];
  assign rp_age  = age_val[1];
  assign cas_age = age_val[2];

  // ---------------- refresh ----------------
  pgdram_refresh #(.ROW_W(ROW_W), .INTERVAL(REF_CYC)) u_ref (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend), .row(ref_row));

  // ---------------- address pins ----------------
  pgdram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W)) u_amux (
    .sel(sel_nx), .row(cur_row), .col(cur_col), .ref_row(ref_row), .addr(addr_nx));

  // ---------------- decisions ----------------
  always_comb begin
    req_ready   = (st == ST_IDLE || st == ST_OPEN) && !ref_pend;
    accept      = req_valid && req_ready;
    hit         = row_open && (open_row == cur_row);
    can_open    = (ras_age >= RC_C) && (rp_age >= RP_C);
    can_close   = (ras_age >= RAS_C);
    can_cas     = (ras_age >= RCD_C) && (cas_age >= PC_C);
    ras_fall_go = 1'b0;
    ras_rise_go = 1'b0;
    cas_fall_go = 1'b0;
    cas_rise_go = 1'b0;
    ref_ack     = 1'b0;
    sel_nx      = ASEL_ROW;
    st_nx       = st;
    unique case (st)
      ST_IDLE: begin
        if (ref_pend) begin
          if (can_open) begin
            ras_fall_go = 1'b1;
            sel_nx      = ASEL_REF;
            st_nx       = ST_REF;
          end
        end else if (accept) begin
          st_nx = ST_ISSUE;
        end
      end
      ST_OPEN: begin
        if (ref_pend) begin
          if (can_close) begin
            ras_rise_go = 1'b1;
            st_nx       = ST_IDLE;
          end
        end else if (accept) begin
          st_nx = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (row_open) begin
          if (hit) begin
            if (can_cas) begin
              cas_fall_go = 1'b1;
              sel_nx      = ASEL_COL;
              st_nx       = ST_CAS;
            end
          end else if (can_close) begin
            ras_rise_go = 1'b1;
          end
        end else if (can_open) begin
          ras_fall_go = 1'b1;
          sel_nx      = ASEL_ROW;
        end
      end
      ST_CAS: begin
        if (cas_age >= CAC_C) begin
          cas_rise_go = 1'b1;
          st_nx       = ST_OPEN;
        end
      end
      ST_REF: begin
        if (can_close) begin
          ras_rise_go = 1'b1;
          ref_ack     = 1'b1;
          st_nx       = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      row_open   <= 1'b0;
      open_row   <= '0;
      cur_we     <= 1'b0;
      cur_row    <= '0;
      cur_col    <= '0;
      cur_wdata  <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_addr  <= '0;
      dram_wdata <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      st        <= st_nx;
      rsp_valid <= 1'b0;
      if (accept) begin
        cur_we    <= req_we;
        cur_row   <= req_addr[ROW_W+COL_W-1:COL_W];
        cur_col   <= req_addr[COL_W-1:0];
        cur_wdata <= req_wdata;
      end
      if (ras_fall_go || cas_fall_go) dram_addr <= addr_nx;
      if (ras_fall_go) begin
        dram_ras_n <= 1'b0;
        if (st == ST_ISSUE) begin
          row_open <= 1'b1;
          open_row <= cur_row;
        end
      end
      if (ras_rise_go) begin
        dram_ras_n <= 1'b1;
        row_open   <= 1'b0;
      end
      if (cas_fall_go) begin
        dram_cas_n <= 1'b0;
        dram_we_n  <= !cur_we;
        dram_wdata <= cur_wdata;
      end
      if (cas_rise_go) begin
        dram_cas_n <= 1'b1;
        dram_we_n  <= 1'b1;
        rsp_valid  <= dram_we_n;
        if (dram_we_n) rsp_rdata <= dram_rdata;
      end
    end
  end

  // ---------------- checks on the pins ----------------
  logic [AGE_W-1:0] mon_ras_low, mon_cas_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_ras_low <= '0;
      mon_cas_low <= '0;
    end else begin
      if (dram_ras_n)              mon_ras_low <= '0;
      else if (mon_ras_low != '1)  mon_ras_low <= mon_ras_low + 1'b1;
      if (dram_cas_n)              mon_cas_low <= '0;
      else if (mon_cas_low != '1)  mon_cas_low <= mon_cas_low + 1'b1;
    end
  end

  assert_ras_low_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> mon_ras_low >= RAS_C);
  assert_cas_low_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cas_n) |-> mon_cas_low >= CAC_C);
  assert_cas_inside_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_rsp_after_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!dram_cas_n) && dram_cas_n);
  assert_refresh_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);
  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: tb/pgdram_ctrl_tb.sv
`timescale 1ns/1ps
module pgdram_ctrl_tb_top;
  localparam int CLK_NS  = 8;
  localparam int T_RAS   = (60 + CLK_NS - 1) / CLK_NS;
  localparam int T_RC    = (110 + CLK_NS - 1) / CLK_NS;
  localparam int T_CAC   = (15 + CLK_NS - 1) / CLK_NS;
  localparam int T_PC    = (35 + CLK_NS - 1) / CLK_NS;
  localparam int T_RP    = (50 + CLK_NS - 1) / CLK_NS;
  localparam int T_RCD   = (45 + CLK_NS - 1) / CLK_NS;
  localparam int REF_CYC = (8000000 + CLK_NS * 256 - 1) / (CLK_NS * 256);
  localparam int WD_LIM  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, dram_ras_n, dram_cas_n, dram_we_n;
  logic [15:0] rsp_rdata, dram_wdata, stub_rd;
  logic [7:0]  dram_addr;

  always #4 clk = ~clk;

  pgdram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(stub_rd));

  // ---------------- DRAM stub ----------------
  logic [15:0] stub_mem [int];
  logic [7:0]  stub_row;
  initial stub_rd = '0;

  function automatic logic [15:0] dflt(input logic [15:0] a);
    return a ^ 16'hA5A5;
  endfunction

  always @(negedge dram_ras_n) begin
    #1 stub_row = dram_addr;
  end
  always @(negedge dram_cas_n) begin
    #1;
    if (!dram_we_n) stub_mem[int'({stub_row, dram_addr})] = dram_wdata;
    else begin
      logic [15:0] v;
      v = stub_mem.exists(int'({stub_row, dram_addr})) ? stub_mem[int'({stub_row, dram_addr})]
                                                       : dflt({stub_row, dram_addr});
      #14 stub_rd = v;
    end
  end

  // ---------------- bookkeeping ----------------
  int nchk = 0, nerr = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  typedef struct {
    bit          we;
    logic [7:0]  row;
    logic [7:0]  col;
    logic [15:0] data;
    bit          hit;
    int          falls;
  } rq_t;

  rq_t         req_q[$];
  logic [15:0] rd_q[$];
  logic [15:0] shadow [int];

  function automatic logic [15:0] model(input logic [15:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
  endfunction

  bit   p_ras = 1, p_cas = 1, p_rv = 0, had_cas = 0;
  int   last_rf = -1000, last_rr = -1000, last_cf = -1000, last_ref = 0;
  int   rfalls = 0, ncas = 0, naccept = 0, nref = 0;
  logic [7:0] lat_row = '0, exp_ref = '0;

  // ---------------- port monitor (samples at falling clock edge) ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_q.size() > 0) chk(!req_ready, "R9 ready while busy", req_ready, 0);
      if (req_valid && req_ready) begin
        rq_t r;
        r.we = req_we; r.row = req_addr[15:8]; r.col = req_addr[7:0]; r.data = req_wdata;
        r.hit = !dram_ras_n && (lat_row == req_addr[15:8]);
        r.falls = rfalls;
        req_q.push_back(r);
        naccept++;
      end
      if (p_ras && !dram_ras_n) begin
        chk(cyc - last_rf >= T_RC, "R4 row cycle", cyc - last_rf, T_RC);
        chk(cyc - last_rr >= T_RP, "R3 precharge", cyc - last_rr, T_RP);
        last_rf = cyc; rfalls++; had_cas = 0; lat_row = dram_addr;
      end
      if (!p_ras && dram_ras_n) begin
        chk(cyc - last_rf >= T_RAS, "R4 row low time", cyc - last_rf, T_RAS);
        if (!had_cas) begin
          chk(lat_row == exp_ref, "R7 refresh row", lat_row, exp_ref);
          chk(cyc - last_ref <= REF_CYC + 80, "R7 refresh gap", cyc - last_ref, REF_CYC + 80);
          last_ref = cyc; exp_ref++; nref++;
        end
        last_rr = cyc;
      end
      if (p_cas && !dram_cas_n) begin
        chk(!dram_ras_n, "R5 cas inside row", dram_ras_n, 0);
        chk(cyc - last_rf >= T_RCD, "R5 row to column", cyc - last_rf, T_RCD);
        chk(cyc - last_cf >= T_PC, "R5 column spacing", cyc - last_cf, T_PC);
        last_cf = cyc; had_cas = 1; ncas++;
        if (req_q.size() == 0) chk(0, "R9 column cycle without request", 1, 0);
        else begin
          rq_t r;
          r = req_q.pop_front();
          chk(lat_row == r.row, "R1 row half", lat_row, r.row);
          chk(dram_addr == r.col, "R1 column half", dram_addr, r.col);
          if (r.hit) chk(rfalls == r.falls, "R2 hit reopened row", rfalls - r.falls, 0);
          else       chk(rfalls == r.falls + 1, "R3 miss row openings", rfalls - r.falls, 1);
          if (r.we) begin
            chk(!dram_we_n, "R6 write enable", dram_we_n, 0);
            chk(dram_wdata == r.data, "R6 write data", dram_wdata, r.data);
            shadow[int'({r.row, r.col})] = r.data;
          end else begin
            chk(dram_we_n, "R6 read enable", dram_we_n, 1);
            rd_q.push_back(model({r.row, r.col}));
          end
        end
      end
      if (!p_cas && dram_cas_n)
        chk(cyc - last_cf >= T_CAC, "R5 column low time", cyc - last_cf, T_CAC);
      if (rsp_valid) begin
        chk(!p_rv, "R6 single pulse", p_rv, 0);
        chk(cyc - last_cf == T_CAC, "R6 read latency", cyc - last_cf, T_CAC);
        if (rd_q.size() == 0) chk(0, "R6 unexpected response", 1, 0);
        else begin
          logic [15:0] e;
          e = rd_q.pop_front();
          chk(rsp_rdata == e, "R6 read data", rsp_rdata, e);
        end
      end
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_rv = rsp_valid;
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input bit we, input logic [15:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic run_all();
    logic [7:0] rows [4];
    logic [7:0] prow;
    int nref0;
    rows[0] = 8'h03; rows[1] = 8'h07; rows[2] = 8'hC8; rows[3] = 8'hFF;
    // reset state
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R10 strobes idle in reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    chk(!rsp_valid, "R10 no response in reset", rsp_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R10 ready after reset", req_ready, 1);
    chk(dram_ras_n, "R10 row strobe after reset", dram_ras_n, 1);
    @(posedge clk); #1;
    // directed: write then read back, same row (hit), address extremes
    do_req(1'b1, 16'h0000, 16'h1234);
    do_req(1'b0, 16'h0000, 16'h0);
    do_req(1'b1, 16'h00FF, 16'hBEEF);
    do_req(1'b0, 16'h00FF, 16'h0);
    do_req(1'b1, 16'hFFFF, 16'hCAFE);
    do_req(1'b0, 16'hFFFF, 16'h0);
    do_req(1'b0, 16'h0000, 16'h0);
    // directed: idle with an open row until refresh closes it
    do_req(1'b1, 16'h0905, 16'h5A5A);
    nref0 = nref;
    repeat (2 * REF_CYC) @(posedge clk);
    @(negedge clk);
    chk(dram_ras_n, "R8 row closed after refresh", dram_ras_n, 1);
    chk(nref > nref0, "R8 refresh ran while idle", nref - nref0, 1);
    @(posedge clk); #1;
    do_req(1'b0, 16'h0905, 16'h0);
    // random traffic with strong row locality
    prow = rows[0];
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] rr;
      int gap;
      rr  = ($urandom % 10 < 7) ? prow : rows[$urandom % 4];
      prow = rr;
      do_req(1'($urandom % 2), {rr, 8'($urandom)}, 16'($urandom));
      gap = $urandom % 4;
      repeat (gap) @(posedge clk);
      #1;
    end
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(req_q.size() == 0, "R9 all requests served", req_q.size(), 0);
    chk(rd_q.size() == 0, "R6 all reads answered", rd_q.size(), 0);
    chk(ncas == naccept, "R9 one column cycle per request", ncas, naccept);
    chk(nref >= cyc / REF_CYC - 1, "R7 refresh count", nref, cyc / REF_CYC - 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_all();
      begin
        wait (cyc >= WD_LIM);
        chk(0, "watchdog", cyc, WD_LIM);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule